// File: doc/BRIEF.md
# Timer-Overridable GPIO Port

An eight-pin bidirectional general-purpose port in which each pin can be handed to a timer. Software reaches the port through a small register bus. It has three registers. The data register holds the output levels. The direction register marks each pin as output (1) or input (0). The input register is read-only and shows the pin levels. The pad inputs pass through a two-flop synchronizer before any read uses them. On a data-register read, each bit gives the stored value when the pin is an output and the synchronized pin level when it is an input.

Two timers with four channels each sit outside the block. For each timer the block receives an enable, a per-channel output-compare flag and a per-channel compare level. The pin goes to the timer when its timer is enabled and the flag of its channel is set. Channel n of the low timer owns pin n and channel n of the high timer owns pin 4+n. An owned pin is driven as an output with the compare level, whatever the GPIO registers hold. The GPIO registers keep their contents, and GPIO control comes back once the timer releases the pin.

The block has no state machine. Its only sequential parts are the two registers and the synchronizer chain, and the state-oriented house layout is kept only for naming, reset and indentation.

Top module: `gtp_port`

## Requirements
- R1: Reset clears the data and direction registers to 0x00. While no timer owns a pin, every pad output enable is low.
- R2: A bus write to offset 2 loads the direction register, and a read of offset 2 returns it.
- R3: A bus write to offset 0 loads the data register. A data-register read bit is the stored bit when that pin's direction bit is 1.
- R4: A data-register read bit (offset 0) is the synchronized pin level when that pin's direction bit is 0.
- R5: A read of offset 1 returns all eight synchronized pin levels, whatever the direction. A pad change becomes visible after two rising clock edges.
- R6: A write to offset 1 changes neither the data register nor the direction register.
- R7: When the low timer is enabled and its channel n output-compare flag is set, pin n has its output enable high and its output equal to the channel n compare level.
- R8: When the high timer is enabled and its channel n output-compare flag is set, pin 4+n has its output enable high and its output equal to the channel n compare level.
- R9: A pin whose timer is disabled, or whose channel flag is clear, stays under GPIO control. Its output value is the data bit and its output enable is the direction bit.
- R10: Timer ownership leaves the data and direction register contents unchanged, and a bus write made while a pin is owned still updates them.
- R11: A read of offset 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| tlo_en | input | 1 | Low timer enable |
| tlo_oc | input | 4 | Low timer output-compare flags, one per channel |
| tlo_lvl | input | 4 | Low timer compare output levels |
| thi_en | input | 1 | High timer enable |
| thi_oc | input | 4 | High timer output-compare flags, one per channel |
| thi_lvl | input | 4 | High timer compare output levels |
| pad_in | input | 8 | Pin levels seen at the pads |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables |

## Verification
A bus write to the data or direction register can land in the same cycle as a timer taking or holding the same pin. The random phase provokes this by drawing a write, a target offset, the timer enables, the flags and the levels together in every vector. The pad outputs must follow the timer while the pin is owned. The register read-back must show the written value, and once the timer releases the pin the pad must return to that value.

// File: rtl/gtp_pkg.sv
package gtp_pkg;
    typedef enum logic [1:0] {
        OFS_DATA  = 2'd0,
        OFS_INPUT = 2'd1,
        OFS_DIR   = 2'd2,
        OFS_NONE  = 2'd3
    } reg_ofs_e;
endpackage

// File: rtl/gtp_sync.sv
module gtp_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // No reset: the input view is left untouched by reset.
    always_ff @(posedge clk) begin
        stg[0] <= d;
        for (int s = 1; s < STAGES; s++) begin
            stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gtp_regs.sv
module gtp_regs
    import gtp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   addr,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] rdata
);
    reg_ofs_e ofs;
    assign ofs = reg_ofs_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (we) begin
            unique case (ofs)
                OFS_DATA:  data_q <= wdata;
                OFS_DIR:   dir_q  <= wdata;
                OFS_INPUT: ;
                OFS_NONE:  ;
            endcase
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_DATA:  rdata = (dir_q & data_q) | (~dir_q & pin_sync);
            OFS_INPUT: rdata = pin_sync;
            OFS_DIR:   rdata = dir_q;
            OFS_NONE:  rdata = '0;
        endcase
    end

    a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd2) |=> dir_q == $past(wdata));
    a_r3_data_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd0) |=> data_q == $past(wdata));
    a_r6_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd1) |=> ($stable(data_q) && $stable(dir_q)));
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (data_q == '0 && dir_q == '0));
endmodule

// File: rtl/gtp_pin_cell.sv
module gtp_pin_cell (
    input  logic own,
    input  logic tmr_lvl,
    input  logic gpio_val,
    input  logic gpio_dir,
    output logic pad_out,
    output logic pad_oe
);
    assign pad_out = own ? tmr_lvl : gpio_val;
    assign pad_oe  = own | gpio_dir;
endmodule

// File: rtl/gtp_port.sv
module gtp_port #(
    parameter int CH          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [2*CH-1:0]   bus_wdata,
    output logic [2*CH-1:0]   bus_rdata,
    input  logic              tlo_en,
    input  logic [CH-1:0]     tlo_oc,
    input  logic [CH-1:0]     tlo_lvl,
    input  logic              thi_en,
    input  logic [CH-1:0]     thi_oc,
    input  logic [CH-1:0]     thi_lvl,
    input  logic [2*CH-1:0]   pad_in,
    output logic [2*CH-1:0]   pad_out,
    output logic [2*CH-1:0]   pad_oe
);
    localparam int W = 2 * CH;

    logic [W-1:0] pin_sync, data_q, dir_q, own, lvl;

    gtp_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pad_in),
        .q   (pin_sync)
    );

    gtp_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .rdata    (bus_rdata)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i < CH) begin : g_lo
            assign own[i] = tlo_en & tlo_oc[i];
            assign lvl[i] = tlo_lvl[i];
        end else begin : g_hi
            assign own[i] = thi_en & thi_oc[i-CH];
            assign lvl[i] = thi_lvl[i-CH];
        end

        gtp_pin_cell u_cell (
            .own      (own[i]),
            .tmr_lvl  (lvl[i]),
            .gpio_val (data_q[i]),
            .gpio_dir (dir_q[i]),
            .pad_out  (pad_out[i]),
            .pad_oe   (pad_oe[i])
        );
    end

    a_r7_low_timer_owns: assert property (@(posedge clk) disable iff (!rst_n)
        (tlo_en && tlo_oc[0]) |-> (pad_oe[0] && pad_out[0] == tlo_lvl[0]));
    a_r8_high_timer_owns: assert property (@(posedge clk) disable iff (!rst_n)
        (thi_en && thi_oc[0]) |-> (pad_oe[CH] && pad_out[CH] == thi_lvl[0]));
    a_r9_released_pin_is_gpio: assert property (@(posedge clk) disable iff (!rst_n)
        (!tlo_en && !thi_en) |-> (pad_oe == dir_q && pad_out == data_q));
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> bus_rdata == '0);
endmodule

// File: tb/tb_gtp_port.sv
module tb_gtp_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tlo_en = 1'b0, thi_en = 1'b0;
    logic [3:0] tlo_oc = 4'h0, tlo_lvl = 4'h0, thi_oc = 4'h0, thi_lvl = 4'h0;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_data = 8'h00, m_dir = 8'h00;

    always #5 clk = ~clk;

    gtp_port dut (.*);

    function automatic logic [7:0] own_mask();
        return {(thi_en ? thi_oc : 4'h0), (tlo_en ? tlo_oc : 4'h0)};
    endfunction
    function automatic logic [7:0] exp_oe();
        return own_mask() | m_dir;
    endfunction
    function automatic logic [7:0] exp_out();
        logic [7:0] o = own_mask();
        return (o & {thi_lvl, tlo_lvl}) | (~o & m_data);
    endfunction
    function automatic logic [7:0] exp_rd0();
        return (m_dir & m_data) | (~m_dir & pad_in);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a == 2'd0) m_data = d;
        if (a == 2'd2) m_dir = d;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic check_all(string tag);
        logic [7:0] v;
        chk({tag, " R7 R8 R9 pad_oe"}, pad_oe, exp_oe());
        chk({tag, " R7 R8 R9 pad_out"}, pad_out, exp_out());
        rd(2'd0, v); chk({tag, " R3 R4 data read"}, v, exp_rd0());
        rd(2'd1, v); chk({tag, " R5 input read"}, v, pad_in);
        rd(2'd2, v); chk({tag, " R2 R10 dir read"}, v, m_dir);
        rd(2'd3, v); chk({tag, " R11 unmapped"}, v, 8'h00);
    endtask

    initial begin : watchdog
        #2ms;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'd1234));
        pad_in = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after reset", pad_oe, 8'h00);
        rd(2'd2, v); chk("R1 dir after reset", v, 8'h00);
        rd(2'd0, v); chk("R4 data read shows pins", v, 8'hA5);
        wr(2'd2, 8'hFF);
        rd(2'd0, v); chk("R1 data after reset", v, 8'h00);

        // R5 latency: one edge is not enough, two are
        pad_in = 8'h3C;
        @(negedge clk);
        rd(2'd1, v); chk("R5 one edge old value", v, 8'hA5);
        @(negedge clk);
        rd(2'd1, v); chk("R5 two edges new value", v, 8'h3C);

        // R3 write and output
        wr(2'd0, 8'h96);
        check_all("directed gpio");
        // R6 write to input offset ignored
        wr(2'd1, 8'h5A);
        check_all("R6 input write");

        // R7 R8 ownership with a write during ownership (R10)
        tlo_en = 1'b1; tlo_oc = 4'b1010; tlo_lvl = 4'b0110;
        thi_en = 1'b1; thi_oc = 4'b0101; thi_lvl = 4'b1001;
        wr(2'd2, 8'h0F);
        wr(2'd0, 8'hC3);
        check_all("directed owned");
        // R9 flag set but timer disabled
        tlo_en = 1'b0; thi_en = 1'b0;
        @(negedge clk);
        check_all("R9 release");
        chk("R10 pad back to data", pad_out, 8'hC3);

        for (int it = 0; it < 400; it++) begin
            @(negedge clk);
            pad_in = 8'($urandom);
            tlo_en = 1'($urandom); thi_en = 1'($urandom);
            tlo_oc = 4'($urandom); thi_oc = 4'($urandom);
            tlo_lvl = 4'($urandom); thi_lvl = 4'($urandom);
            if (($urandom % 3) != 0) wr(2'($urandom), 8'($urandom));
            settle();
            check_all("random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule